// File: doc/BRIEF.md
# Comma-Triggered Latency Stopwatch

This block times the delay between two comma events on a serial data path. A start comma can be taken from the four parallel low-speed transmit lanes or from the two 10-bit halves of the high-speed receive word. A stop comma can be taken from the four low-speed receive lanes or from the two halves of the high-speed transmit word. One select bit picks each source. Comma detection is done elsewhere; this block receives one-cycle strobes, one per lane or per half-word.

Counting is in units of half a measurement-clock period. The counter advances by two on each clock. A phase input on each side marks a comma that arrived in the second half of its clock period, which corrects the last bit. When the stop comma arrives, the count freezes and a ready flag rises. The lanes that carried the start comma and the lanes that carried the stop comma are latched for software to inspect.

Software reads through a small register port. It reads the status word first and the count word second. Reading the count word clears the whole measurement and re-arms the stopwatch. The port is a plain request with a fixed one-cycle response. It has no back-pressure: every request is answered on the next cycle, and a request can be issued on every cycle.

Top module: `latency_stopwatch`

## Requirements
- R1: After reset, the status word (address 0) and the count word (address 1) both read as zero.
- R2: With the start select at 0, the first low-speed transmit strobe after re-arm starts the measurement. Status bits [15:12] latch that cycle's lane strobes, with bit 12+i standing for lane i.
- R3: With a select at 1, the high-speed half-words replace the lanes. Flag bit 0 stands for data[9:0] and bit 1 for data[19:10]; flag bits 2 and 3 stay zero. Strobes on the source that is not selected have no effect.
- R4: A stop strobe counts only while a measurement runs. It latches that cycle's stop strobes into status bits [11:8], using the same mapping as R2 and R3 under its own select. A stop strobe seen before any start is ignored.
- R5: With D clock edges between the start edge and the stop edge, the final count is 2*D + stop_late - start_late.
- R6: The count saturates at 2^CNT_W - 1 and does not wrap.
- R7: Status bit 4 (ready) rises with the stop. After that, further start or stop strobes change neither the count nor any flag.
- R8: Until ready is set, both the count word and status bits [3:0] read as zero.
- R9: The status word is {start flags[15:12], stop flags[11:8], zero in [7:5], ready in [4], count[19:16] in [3:0]}. The count word holds count[15:0].
- R10: Reading the count word clears the count, all flags and ready, and re-arms the stopwatch. Reading the status word changes nothing.
- R11: A start or stop strobe in the same cycle as a count-word read is dropped; the clear wins.
- R12: A read request on one cycle gives rd_valid and rd_data on the next cycle. The data shows the state as it was before that request's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_sel | input | 1 | 0: start on low-speed TX lanes; 1: start on high-speed RX half-words |
| stop_sel | input | 1 | 0: stop on low-speed RX lanes; 1: stop on high-speed TX half-words |
| ls_tx_comma | input | 4 | Comma strobes, low-speed transmit lanes |
| hs_rx_comma | input | 2 | Comma strobes, high-speed receive half-words |
| start_late | input | 1 | Start comma arrived in the second half of the clock period |
| ls_rx_comma | input | 4 | Comma strobes, low-speed receive lanes |
| hs_tx_comma | input | 2 | Comma strobes, high-speed transmit half-words |
| stop_late | input | 1 | Stop comma arrived in the second half of the clock period |
| rd_en | input | 1 | Read request |
| rd_addr | input | 1 | 0: status word, 1: count word (clear on read) |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 16 | Read data |

## Verification
Random runs draw the start and stop selects, the strobe masks, both phase bits and gaps of 1 to 200 cycles. This checks the 2*D correction and the lane and half-word flag mapping. Garbage is driven on the source that is not selected, which separates a correct select from one that merges both sources. Extra start strobes during a run and extra strobes after the stop tell a frozen measurement from one that restarts or keeps counting. Directed cases then cover:
- reads before any stop, which must return zero;
- a status read followed by a second status read, which tells a read with no side effect from a clearing one;
- a clear in the same cycle as a strobe;
- a stop with no start;
- a long run that reaches saturation.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int SW_FLAGS  = 4;   // flag bits per side in the status word
  localparam int SW_HALVES = 2;   // 10-bit halves of a high-speed word
  localparam int SW_FULL_W = 20;  // architectural count width
  localparam int SW_WORD_W = 16;  // register word width

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RUN  = 2'd1,
    SW_DONE = 2'd2
  } sw_state_e;
endpackage

// File: rtl/sw_src_mux.sv
module sw_src_mux #(
  parameter int LANES  = 4,
  parameter int HALVES = 2
) (
  input  logic              sel,
  input  logic [LANES-1:0]  lane_stb,
  input  logic [HALVES-1:0] half_stb,
  output logic [LANES-1:0]  flags,
  output logic              hit
);
  // Lane mode maps lane i to flag i. Half-word mode fills the low flags and
  // forces the rest to zero.
  for (genvar i = 0; i < LANES; i++) begin : g_flag
    if (i < HALVES) begin : g_shared
      assign flags[i] = sel ? half_stb[i] : lane_stb[i];
    end else begin : g_lane_only
      assign flags[i] = sel ? 1'b0 : lane_stb[i];
    end
  end

  assign hit = |flags;
endmodule

// File: rtl/sw_counter.sv
module sw_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             run,
  input  logic             stop,
  input  logic             start_late,
  input  logic             stop_late,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             late_q;
  logic [1:0]       step;
  logic [CNT_W:0]   sum;

  // Every clock adds two half-periods. The last step corrects for the phases.
  always_comb begin
    if (stop) begin
      if (late_q) step = stop_late ? 2'd2 : 2'd1;
      else        step = stop_late ? 2'd3 : 2'd2;
    end else begin
      step = 2'd2;
    end
    sum = {1'b0, cnt} + (CNT_W+1)'(step);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      late_q <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      late_q <= 1'b0;
    end else if (load) begin
      cnt    <= '0;
      late_q <= start_late;
    end else if (run) begin
      if (sum[CNT_W]) cnt <= CNT_MAX;
      else            cnt <= sum[CNT_W-1:0];
    end
  end

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !load && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R5
  cnt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !load) |=> (cnt > $past(cnt) || cnt == CNT_MAX));
endmodule

// File: rtl/sw_regs.sv
module sw_regs
  import sw_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 rd_addr,
  input  logic [SW_FLAGS-1:0]  start_flags,
  input  logic [SW_FLAGS-1:0]  stop_flags,
  input  logic                 ready,
  input  logic [CNT_W-1:0]     cnt,
  output logic                 clr,
  output logic                 rd_valid,
  output logic [SW_WORD_W-1:0] rd_data
);
  logic [SW_FULL_W-1:0] cnt_full;
  logic [SW_FULL_W-1:0] shown;
  logic [SW_WORD_W-1:0] status_w;
  logic [SW_WORD_W-1:0] count_w;
  logic                 last_addr;

  always_comb begin
    cnt_full = SW_FULL_W'(cnt);
    shown    = ready ? cnt_full : '0;
    status_w = {start_flags, stop_flags, 3'b000, ready,
                shown[SW_FULL_W-1:SW_WORD_W]};
    count_w  = shown[SW_WORD_W-1:0];
  end

  assign clr = rd_en & rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      last_addr <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data   <= rd_addr ? count_w : status_w;
        last_addr <= rd_addr;
      end
    end
  end

  // R12
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R12
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !last_addr) |-> (rd_data[7:5] == 3'b000));
endmodule

// File: rtl/latency_stopwatch.sv
module latency_stopwatch
  import sw_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_sel,
  input  logic        stop_sel,
  input  logic [3:0]  ls_tx_comma,
  input  logic [1:0]  hs_rx_comma,
  input  logic        start_late,
  input  logic [3:0]  ls_rx_comma,
  input  logic [1:0]  hs_tx_comma,
  input  logic        stop_late,
  input  logic        rd_en,
  input  logic        rd_addr,
  output logic        rd_valid,
  output logic [15:0] rd_data
);
  sw_state_e            state;
  logic [SW_FLAGS-1:0]  start_vec, stop_vec;
  logic                 start_hit, stop_hit;
  logic [SW_FLAGS-1:0]  start_flags, stop_flags;
  logic [CNT_W-1:0]     cnt;
  logic                 clr;
  logic                 ready;
  logic                 do_load, do_run;

  sw_src_mux #(.LANES(SW_FLAGS), .HALVES(SW_HALVES)) u_start_mux (
    .sel(start_sel), .lane_stb(ls_tx_comma), .half_stb(hs_rx_comma),
    .flags(start_vec), .hit(start_hit)
  );

  sw_src_mux #(.LANES(SW_FLAGS), .HALVES(SW_HALVES)) u_stop_mux (
    .sel(stop_sel), .lane_stb(ls_rx_comma), .half_stb(hs_tx_comma),
    .flags(stop_vec), .hit(stop_hit)
  );

  assign ready   = (state == SW_DONE);
  assign do_load = (state == SW_IDLE) && start_hit;
  assign do_run  = (state == SW_RUN);

  // Sequencer. A clear overrides any event in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state       <= SW_IDLE;
      start_flags <= '0;
      stop_flags  <= '0;
    end else begin
      unique case (state)
        SW_IDLE: if (start_hit) begin
          state       <= SW_RUN;
          start_flags <= start_vec;
        end
        SW_RUN: if (stop_hit) begin
          state      <= SW_DONE;
          stop_flags <= stop_vec;
        end
        default: state <= SW_DONE;
      endcase
    end
  end

  sw_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(do_load), .run(do_run),
    .stop(stop_hit), .start_late(start_late), .stop_late(stop_late),
    .cnt(cnt)
  );

  sw_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .start_flags(start_flags), .stop_flags(stop_flags), .ready(ready),
    .cnt(cnt), .clr(clr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R7
  ready_has_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (stop_flags != '0 && start_flags != '0));

  // R7
  done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !clr) |=> ($stable(cnt) && $stable(start_flags) && $stable(stop_flags) && ready));

  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == SW_IDLE && start_flags == '0 && stop_flags == '0 && cnt == '0));

  // R4
  stop_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_IDLE) |=> (stop_flags == '0));
endmodule

// File: tb/tb_latency_stopwatch.sv
module tb_latency_stopwatch;
  localparam int CW = 17;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_sel = 0, stop_sel = 0, start_late = 0, stop_late = 0;
  logic [3:0] ls_tx_comma = 0, ls_rx_comma = 0;
  logic [1:0] hs_rx_comma = 0, hs_tx_comma = 0;
  logic rd_en = 0, rd_addr = 0;
  logic rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] got;

  always #5 clk = ~clk;

  latency_stopwatch #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_sel(start_sel), .stop_sel(stop_sel),
    .ls_tx_comma(ls_tx_comma), .hs_rx_comma(hs_rx_comma), .start_late(start_late),
    .ls_rx_comma(ls_rx_comma), .hs_tx_comma(hs_tx_comma), .stop_late(stop_late),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic int exp_cnt(int d, bit ps, bit pe);
    int v = 2 * d + int'(pe) - int'(ps);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic logic [15:0] exp_status(logic [3:0] sf, logic [3:0] ef,
                                             bit rdy, int c);
    logic [19:0] cf = rdy ? 20'(c) : 20'd0;
    return {sf, ef, 3'b000, rdy, cf[19:16]};
  endfunction

  task automatic chk(string tag, logic [15:0] a, logic [15:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, a, e);
    end
  endtask

  // Moves to the next falling edge and drops all strobes and requests.
  task automatic tick();
    @(negedge clk);
    ls_tx_comma = 0; hs_rx_comma = 0; ls_rx_comma = 0; hs_tx_comma = 0;
    start_late = 0; stop_late = 0; rd_en = 0;
  endtask

  task automatic rd(bit a, output logic [15:0] d);
    rd_en = 1; rd_addr = a;
    tick();
    chk("R12 valid", {15'd0, rd_valid}, 16'd1);
    d = rd_data;
  endtask

  task automatic fire_start(logic [3:0] ls, logic [1:0] hs, bit late);
    ls_tx_comma = ls; hs_rx_comma = hs; start_late = late;
  endtask

  task automatic fire_stop(logic [3:0] ls, logic [1:0] hs, bit late);
    ls_rx_comma = ls; hs_tx_comma = hs; stop_late = late;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R1 reset state
    rd(0, got); chk("R1 status", got, 16'h0000);
    rd(1, got); chk("R1 count", got, 16'h0000);

    // R4 stop before start is ignored
    fire_stop(4'hF, 2'b11, 1); tick(); tick();
    rd(0, got); chk("R4 stop without start", got, 16'h0000);

    // R8 read while running: zero count, flags visible; count read clears (R10)
    start_sel = 0; stop_sel = 0;
    fire_start(4'b0101, 2'b00, 0); tick();
    repeat (5) tick();
    rd(0, got); chk("R8 status while running", got, exp_status(4'b0101, 4'b0000, 0, 0));
    rd(1, got); chk("R8 count while running", got, 16'h0000);
    rd(0, got); chk("R10 cleared after count read", got, 16'h0000);

    // R11 clear wins over a same-cycle start
    fire_start(4'b1000, 2'b00, 0); rd(1, got);
    tick();
    rd(0, got); chk("R11 start dropped", got, 16'h0000);

    // R5 minimal gap, start late and stop early
    fire_start(4'b0010, 2'b00, 1); tick();
    fire_stop(4'b0001, 2'b00, 0); tick();
    rd(0, got); chk("R5 status d=1", got, exp_status(4'b0010, 4'b0001, 1, exp_cnt(1, 1, 0)));
    rd(0, got); chk("R10 status read keeps state", got, exp_status(4'b0010, 4'b0001, 1, exp_cnt(1, 1, 0)));
    rd(1, got); chk("R5 count d=1", got, 16'(exp_cnt(1, 1, 0)));

    // R3 half-word mode with lane garbage
    start_sel = 1; stop_sel = 1;
    fire_start(4'hF, 2'b10, 0); tick();
    repeat (2) tick();
    fire_stop(4'hF, 2'b01, 1); tick();
    rd(0, got); chk("R3 half-word flags", got, exp_status(4'b0010, 4'b0001, 1, exp_cnt(3, 0, 1)));
    rd(1, got); chk("R3 count", got, 16'(exp_cnt(3, 0, 1)));

    // Random measurements
    for (int it = 0; it < 40; it++) begin
      bit ss = 1'($urandom); bit es = 1'($urandom);
      logic [3:0] sl = 4'($urandom_range(1, 15)); logic [1:0] sh = 2'($urandom_range(1, 3));
      logic [3:0] el = 4'($urandom_range(1, 15)); logic [1:0] eh = 2'($urandom_range(1, 3));
      bit ps = 1'($urandom); bit pe = 1'($urandom);
      int d = $urandom_range(1, 200);
      logic [3:0] sf, ef;
      int c;
      start_sel = ss; stop_sel = es;
      sf = ss ? {2'b00, sh} : sl;
      ef = es ? {2'b00, eh} : el;
      // Garbage on the unselected side only (R3)
      fire_start(ss ? 4'($urandom) : sl, ss ? sh : 2'($urandom), ps); tick();
      for (int k = 1; k < d; k++) begin
        if (($urandom % 8) == 0) fire_start(4'hF, 2'b11, 1);  // R7 extra starts ignored
        tick();
      end
      fire_stop(es ? 4'($urandom) : el, es ? eh : 2'($urandom), pe); tick();
      repeat ($urandom_range(0, 3)) begin
        fire_start(4'hF, 2'b11, 0); fire_stop(4'hF, 2'b11, 1); tick();  // R7
      end
      c = exp_cnt(d, ps, pe);
      rd(0, got); chk("R2/R4/R9 random status", got, exp_status(sf, ef, 1, c));
      rd(1, got); chk("R5 random count", got, 16'(c));
      rd(0, got); chk("R10 random re-arm", got, 16'h0000);
    end

    // R6 saturation
    start_sel = 0; stop_sel = 0;
    fire_start(4'b0001, 2'b00, 0); tick();
    repeat (69999) tick();
    fire_stop(4'b1000, 2'b00, 1); tick();
    rd(0, got); chk("R6 saturated status", got, exp_status(4'b0001, 4'b1000, 1, MAXV));
    rd(1, got); chk("R6 saturated count", got, 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule